// File: doc/BRIEF.md
# Subword Bit Gather and Scatter Unit

This unit moves the bits of a data word under the control of a mask word. It works inside every aligned subword of the word independently, and a 3-bit size code picks the subword width. In gather mode, the data bits that sit at the mask's set positions are packed together against one end of their subword, and every other bit of that subword is cleared. In scatter mode, the unit does the reverse. It takes data bits in order from one end of the subword and places them, one by one, at the mask's set positions. All other positions are cleared.

A direction input picks the end. "Toward LSB" packs against, or draws from, bit 0 of the subword. "Toward MSB" does the same at the top bit of the subword. Bits never move from one subword into another. The result is registered and appears one clock after the request, together with a valid strobe.

Top module: `scx_unit`

## Requirements
- R1: Gather toward LSB (in_scatter=0, in_to_msb=0): in each subword, the data bits at mask-1 positions are placed at subword bits 0,1,2,… in ascending source order, and all higher bits of the subword are 0. Example for a byte: data 0xB5 with mask 0x9A gives 0x0C.
- R2: Scatter toward LSB (in_scatter=1, in_to_msb=0): in each subword, the data bits from subword bit 0 upward are placed at the mask-1 positions in ascending order, and all other positions are 0. Example for a byte: data 0xB5 with mask 0x9A gives 0x12.
- R3: Gather toward MSB (in_scatter=0, in_to_msb=1): the selected bits are packed against the top bit of the subword, in their original order, and all lower bits are 0. Example for a byte: data 0xB5 with mask 0x9A gives 0xC0.
- R4: Scatter toward MSB (in_scatter=1, in_to_msb=1): the data bits are taken from the top bit of the subword downward and placed at the mask-1 positions from the top downward. All other positions are 0. Example for a byte: data 0xB5 with mask 0x9A gives 0x8A.
- R5: The size code in_sw selects subwords of 1<<in_sw bits, each starting at a multiple of its size. No bit crosses a subword boundary.
- R6: A size code above log2(WIDTH) (6 or 7 for 32 bits) behaves as log2(WIDTH), which is one full-word subword.
- R7: An all-zero mask gives an all-zero result. An all-ones mask gives a result equal to the data, for both modes and both directions.
- R8: Scattering the result of a gather, with the same mask, size and direction, returns data AND mask.
- R9: After reset, out_valid and out_result are 0. A request accepted with in_valid=1 appears on out_result one clock later, with out_valid=1. out_valid is 0 in the cycle after a clock with in_valid=0.
- R10: While in_valid is 0, out_result keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_data | input | WIDTH | Data word |
| in_mask | input | WIDTH | Selection mask |
| in_sw | input | SEL_W | Subword size code, subword = 1<<in_sw bits |
| in_scatter | input | 1 | 0 = gather, 1 = scatter |
| in_to_msb | input | 1 | 0 = toward bit 0, 1 = toward subword top |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_result | output | WIDTH | Registered result |

## Verification
The assertions assume that in_valid, in_scatter, in_to_msb, in_sw and in_mask are known at every rising edge outside reset. They also assume that a request's inputs are stable around the edge that samples them. The full-word packing checks apply only when the size code asks for a full-word subword. The bench meets these assumptions by changing every input only on falling edges and by never leaving an input undriven. The sweep covers every size code, including the codes that are clamped, both modes and both directions. Its masks include all zeros, all ones, alternating patterns and pseudo-random words.

// File: rtl/scx_pkg.sv
package scx_pkg;

   // Operation select: gather (compress) or scatter (expand)
   typedef enum logic {
      SCX_GATHER  = 1'b0,
      SCX_SCATTER = 1'b1
   } scx_op_e;

   // Side of the subword that bits are packed against or drawn from
   typedef enum logic {
      SCX_TO_LSB = 1'b0,
      SCX_TO_MSB = 1'b1
   } scx_dir_e;

endpackage

// File: rtl/scx_lane.sv
// One subword, LSB-side gather or scatter.
module scx_lane #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] src,
   input  logic [LANE_W-1:0] sel,
   input  logic              scatter,
   output logic [LANE_W-1:0] dst
);
   localparam int IW = (LANE_W > 1) ? $clog2(LANE_W) : 1;

   initial begin
      if (LANE_W < 1) $error("scx_lane: LANE_W must be at least 1");
   end

   logic [IW-1:0] rank;

   always_comb begin
      dst  = '0;
      rank = '0;
      for (int j = 0; j < LANE_W; j++) begin
         if (sel[j]) begin
            if (scatter) dst[j]    = src[rank];
            else         dst[rank] = src[j];
            rank = rank + 1'b1;
         end
      end
   end
endmodule

// File: rtl/scx_level.sv
// All subwords of one fixed size, with optional mirroring for the MSB side.
module scx_level #(
   parameter int WIDTH = 32,
   parameter int SW    = 3
) (
   input  logic [WIDTH-1:0] data,
   input  logic [WIDTH-1:0] mask,
   input  logic             scatter,
   input  logic             to_msb,
   output logic [WIDTH-1:0] res
);
   localparam int LANE  = 1 << SW;
   localparam int NLANE = WIDTH / LANE;

   initial begin
      if (LANE > WIDTH) $error("scx_level: subword wider than word");
   end

   logic [WIDTH-1:0] d_m, m_m, r_m;

   // Mirroring inside a subword flips the low SW index bits: i -> i ^ (LANE-1)
   for (genvar i = 0; i < WIDTH; i++) begin : g_mirror
      localparam int MI = i ^ (LANE - 1);
      assign d_m[i] = to_msb ? data[MI] : data[i];
      assign m_m[i] = to_msb ? mask[MI] : mask[i];
      assign res[i] = to_msb ? r_m[MI]  : r_m[i];
   end

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      scx_lane #(.LANE_W(LANE)) i_lane (
         .src    (d_m[l*LANE +: LANE]),
         .sel    (m_m[l*LANE +: LANE]),
         .scatter(scatter),
         .dst    (r_m[l*LANE +: LANE])
      );
   end
endmodule

// File: rtl/scx_unit.sv
module scx_unit
   import scx_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int LOG2  = $clog2(WIDTH),
   localparam int SEL_W = $clog2(LOG2 + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   input  logic [WIDTH-1:0] in_mask,
   input  logic [SEL_W-1:0] in_sw,
   input  logic             in_scatter,
   input  logic             in_to_msb,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_result
);
   if (WIDTH < 2 || WIDTH != (1 << LOG2)) begin : g_bad_width
      $error("scx_unit: WIDTH must be a power of two, at least 2");
   end

   scx_op_e  op;
   scx_dir_e dir;
   assign op  = scx_op_e'(in_scatter);
   assign dir = scx_dir_e'(in_to_msb);

   // Clamp of oversize codes to the full word
   logic [SEL_W-1:0] sw_eff;
   assign sw_eff = (in_sw > SEL_W'(LOG2)) ? SEL_W'(LOG2) : in_sw;

   logic [WIDTH-1:0] lvl_res [LOG2+1];

   for (genvar s = 0; s <= LOG2; s++) begin : g_level
      scx_level #(.WIDTH(WIDTH), .SW(s)) i_level (
         .data   (in_data),
         .mask   (in_mask),
         .scatter(op == SCX_SCATTER),
         .to_msb (dir == SCX_TO_MSB),
         .res    (lvl_res[s])
      );
   end

   logic [WIDTH-1:0] nxt;
   always_comb begin
      nxt = '0;
      for (int k = 0; k <= LOG2; k++) begin
         if (sw_eff == SEL_W'(k)) nxt = lvl_res[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_result <= nxt;
      end
   end

   // R9: strobe follows the request by one clock
   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R10: result held while idle
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));
   // R7: zero mask gives zero, full mask passes data
   a_r7_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mask == '0) |=> out_result == '0);
   a_r7_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mask == '1) |=> out_result == $past(in_data));
   // R2: scatter never sets a bit outside the mask
   a_r2_scatter_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_scatter) |=> (out_result & ~$past(in_mask)) == '0);
   // R1: full-word gather toward LSB leaves everything above the count clear
   a_r1_gather_lsb_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_scatter && !in_to_msb && in_sw >= SEL_W'(LOG2))
      |=> (out_result >> $past($countones(in_mask))) == '0);
   // R3: full-word gather toward MSB leaves everything below clear
   a_r3_gather_msb_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_scatter && in_to_msb && in_sw >= SEL_W'(LOG2))
      |=> (out_result << $past($countones(in_mask))) == '0);
   // R1/R3: gather never produces more ones than the mask holds
   a_r1_gather_popcount: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_scatter)
      |=> $countones(out_result) <= $past($countones(in_mask)));
endmodule

// File: tb/test_scx_unit.sv
module test_scx_unit;
   localparam int W = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic [31:0] in_mask = '0;
   logic [2:0]  in_sw = '0;
   logic        in_scatter = 1'b0;
   logic        in_to_msb = 1'b0;
   logic        out_valid;
   logic [31:0] out_result;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic [31:0] lfsr = 32'hACE1_2468;

   always #5 clk = ~clk;

   scx_unit #(.WIDTH(W)) i_scx_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_mask(in_mask), .in_sw(in_sw), .in_scatter(in_scatter),
      .in_to_msb(in_to_msb), .out_valid(out_valid), .out_result(out_result)
   );

   function automatic logic [31:0] ref_op(logic [31:0] d, logic [31:0] m,
                                           int sw, bit scat, bit left);
      int s = (sw > 5) ? 5 : sw;
      int n = 1 << s;
      logic [31:0] r = '0;
      for (int base = 0; base < 32; base += n) begin
         int k = 0;
         if (!left) begin
            for (int j = 0; j < n; j++) begin
               if (m[base+j]) begin
                  if (!scat) r[base+k] = d[base+j];
                  else       r[base+j] = d[base+k];
                  k++;
               end
            end
         end else begin
            for (int j = n - 1; j >= 0; j--) begin
               if (m[base+j]) begin
                  if (!scat) r[base+n-1-k] = d[base+j];
                  else       r[base+j]     = d[base+n-1-k];
                  k++;
               end
            end
         end
      end
      return r;
   endfunction

   function automatic logic [31:0] next_rand(logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called at a falling edge; checks at the next falling edge
   task automatic apply(logic [31:0] d, logic [31:0] m, int sw, bit scat,
                        bit left, string req, logic [31:0] exp);
      in_valid = 1'b1; in_data = d; in_mask = m; in_sw = 3'(sw);
      in_scatter = scat; in_to_msb = left;
      @(negedge clk);
      check(req, out_result, exp);
      check({req, " valid"}, {31'b0, out_valid}, 32'd1);
   endtask

   function automatic string req_of(bit scat, bit left);
      if (!scat) return left ? "R3" : "R1";
      return left ? "R4" : "R2";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] g, dd, mm;
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 reset result", out_result, 32'h0);
      check("R9 reset valid", {31'b0, out_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1-R4 byte examples, replicated in every byte (R5)
      apply(32'hB5B5_B5B5, 32'h9A9A_9A9A, 3, 0, 0, "R1", 32'h0C0C_0C0C);
      apply(32'hB5B5_B5B5, 32'h9A9A_9A9A, 3, 1, 0, "R2", 32'h1212_1212);
      apply(32'hB5B5_B5B5, 32'h9A9A_9A9A, 3, 0, 1, "R3", 32'hC0C0_C0C0);
      apply(32'hB5B5_B5B5, 32'h9A9A_9A9A, 3, 1, 1, "R4", 32'h8A8A_8A8A);
      // R5 subwords independent: only one byte has mask bits
      apply(32'hFFFF_FFFF, 32'h0000_8000, 3, 0, 0, "R5", 32'h0000_0100);
      // R6 clamp: codes 6 and 7 act as full word
      apply(32'h8000_0001, 32'h8000_0001, 7, 0, 0, "R6", 32'h0000_0003);
      apply(32'h8000_0001, 32'h8000_0001, 6, 0, 1, "R6", 32'hC000_0000);
      // R7 extremes
      apply(32'h1234_5678, 32'h0, 2, 1, 1, "R7 zero", 32'h0);
      apply(32'h1234_5678, 32'hFFFF_FFFF, 4, 0, 1, "R7 ones", 32'h1234_5678);

      // R10 hold while idle with changing inputs
      in_valid = 1'b0; in_data = 32'hDEAD_BEEF; in_mask = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R10 hold", out_result, 32'h1234_5678);
      check("R9 idle valid", {31'b0, out_valid}, 32'h0);

      // Sweep: every size code, mode and direction
      for (int sw = 0; sw < 8; sw++) begin
         for (int op = 0; op < 2; op++) begin
            for (int dr = 0; dr < 2; dr++) begin
               for (int v = 0; v < 24; v++) begin
                  lfsr = next_rand(lfsr); dd = lfsr;
                  lfsr = next_rand(lfsr); mm = lfsr;
                  if (v == 0) mm = 32'h0;
                  if (v == 1) mm = 32'hFFFF_FFFF;
                  if (v == 2) mm = 32'hAAAA_AAAA;
                  if (v == 3) mm = 32'h0F0F_3C3C;
                  if (v == 4) mm = mm & lfsr[15:0];
                  apply(dd, mm, sw, bit'(op), bit'(dr),
                        (v < 2) ? "R7" : ((sw > 5) ? "R6" : req_of(bit'(op), bit'(dr))),
                        ref_op(dd, mm, sw, bit'(op), bit'(dr)));
               end
            end
         end
      end

      // R8 round trip: gather then scatter with the same controls
      for (int sw = 0; sw < 6; sw++) begin
         for (int dr = 0; dr < 2; dr++) begin
            for (int v = 0; v < 6; v++) begin
               lfsr = next_rand(lfsr); dd = lfsr;
               lfsr = next_rand(lfsr); mm = lfsr;
               apply(dd, mm, sw, 0, bit'(dr), "R8 gather",
                     ref_op(dd, mm, sw, 0, bit'(dr)));
               g = out_result;
               apply(g, mm, sw, 1, bit'(dr), "R8", dd & mm);
            end
         end
      end

      in_valid = 1'b0;
      @(negedge clk);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule